// File: doc/BRIEF.md
# Delayed Single-Shot Block Copy Engine

This block moves one block of data between host memory and a 4096-byte on-chip scratch buffer. The host programs four 64-bit registers: source address, destination address, byte count and command. Writing the command register with its run bit set arms a programmable delay. When the delay expires, the engine copies the block one 32-bit word per memory handshake. When the copy finishes, the engine clears run and, if asked, pulses an interrupt request.

The buffer side of a transfer is named by a device address inside a fixed 4 KiB window, and that range is validated before any data moves. The host side is cut to 28 bits. A transfer whose buffer range fails the check sets a sticky error flag and ends without touching memory. A separate word port gives the host direct read and write access to the buffer, for filling it before a copy out and for reading it after a copy in.

Top module: `dly_dma`

## Requirements
- R1: After reset the four registers read zero, `mem_req`, `irq_o` and `range_err` are low, and a read of any offset other than 0x80, 0x88, 0x90 or 0x98 returns all ones.
- R2: Offsets 0x80, 0x88, 0x90 and 0x98 hold source, destination, count and command. A write with `reg_size` 8 stores all 64 bits. A write with `reg_size` 4 stores the low 32 bits and zeroes the upper half. Writes of any other size are dropped. The command register reads back its bits 2:0 with all other bits zero.
- R3: While command bit 0 (run) is set, writes to all four registers are dropped. A command write whose bit 0 is clear is dropped entirely.
- R4: Writing command bit 0 = 1 starts a transfer. Bit 1 selects the direction (0: host memory into the buffer, 1: buffer out to host memory) and bit 2 asks for an interrupt. `mem_req` stays low for exactly `DELAY_CYCLES` cycles after the write edge. Run reads 1 until completion and then 0, while bits 2:1 keep their values.
- R5: The buffer address B is the low 32 bits of the destination register for direction 0, or of the source register for direction 1. With E = B + count (low 32 bits, wrapping), the range is valid only if B and E both lie in [0x40000, 0x41000) and E > B. A transfer that ends exactly at 0x41000, or has a count of zero, is invalid. An invalid range sets `range_err` (sticky until reset), makes no memory request and clears run.
- R6: The host address is the other register, masked to its low 28 bits with bits 1:0 dropped. Word k of a transfer uses `mem_addr` = host word address + k, shown as a byte address.
- R7: For direction 0, each `mem_ack` writes `mem_rdata` into buffer word ((B − 0x40000) >> 2) + k. On a final partial word only byte lanes 0 .. (count mod 4) − 1 change. Buffer byte lane i is bits 8i+7:8i.
- R8: For direction 1, `mem_we` is 1 and `mem_wdata` is the buffer word. `mem_be` is 4'hF except on a final partial word, where only the low (count mod 4) lanes are set. The number of words is ceil(count/4).
- R9: `mem_req` is held with stable `mem_addr` and `mem_be` until `mem_ack`.
- R10: At completion, including a range error, `irq_o` pulses high for one cycle if command bit 2 was set, and stays low otherwise.
- R11: `buf_wr` writes `buf_wdata` into buffer word `buf_idx`. `buf_rdata` shows word `buf_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 4 | Write access size in bytes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| buf_wr | input | 1 | Buffer word write strobe |
| buf_idx | input | 10 | Buffer word index |
| buf_wdata | input | 32 | Buffer write data |
| buf_rdata | output | 32 | Buffer read data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 28 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory handshake complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| irq_o | output | 1 | One-cycle completion interrupt request |
| range_err | output | 1 | Sticky buffer range error |

## Verification
The bench targets these corner cases:
- Trailing partial words in both directions. An engine with wrong byte enables would overwrite buffer or host bytes past the end of the count.
- A range that ends exactly at the window top, a range starting below the window, and a zero count. A careless range check would let any of these start a copy.
- Host addresses with bits set above bit 27. An engine without the mask would issue addresses outside the 28-bit space.
- Register writes during the delay, and a command write without run. An engine without the lock would retarget or restart a transfer already in flight.
- A memory that stalls its acknowledge. An engine that advanced early would change `mem_addr` before the acknowledge arrives.

// File: rtl/dly_dma.sv
module dly_dma #(
  parameter int          DELAY_CYCLES = 16,
  parameter logic [31:0] WIN_BASE     = 32'h0004_0000,
  parameter int          BUF_BYTES    = 4096,
  parameter int          HOST_AW      = 28
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [7:0]                     reg_addr,
  input  logic [3:0]                     reg_size,
  input  logic [63:0]                    reg_wdata,
  output logic [63:0]                    reg_rdata,
  input  logic                           buf_wr,
  input  logic [$clog2(BUF_BYTES)-3:0]   buf_idx,
  input  logic [31:0]                    buf_wdata,
  output logic [31:0]                    buf_rdata,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [HOST_AW-1:0]             mem_addr,
  output logic [31:0]                    mem_wdata,
  output logic [3:0]                     mem_be,
  input  logic                           mem_ack,
  input  logic [31:0]                    mem_rdata,
  output logic                           irq_o,
  output logic                           range_err
);
  localparam int BW    = $clog2(BUF_BYTES);
  localparam int IW    = BW - 2;
  localparam int WORDS = BUF_BYTES / 4;
  localparam int HW    = HOST_AW - 2;
  localparam int DW    = $clog2(DELAY_CYCLES + 1);
  localparam logic [32:0] WIN_END = {1'b0, WIN_BASE} + 33'(BUF_BYTES);
  localparam logic [7:0] A_SRC = 8'h80, A_DST = 8'h88, A_CNT = 8'h90, A_CMD = 8'h98;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} st_t;

  function automatic logic in_win(input logic [31:0] a);
    return ({1'b0, a} >= {1'b0, WIN_BASE}) && ({1'b0, a} < WIN_END);
  endfunction

  logic [63:0]   src_q, dst_q, cnt_q;
  logic [2:0]    cmd_q;
  st_t           st_q;
  logic [DW-1:0] dly_q;
  logic [IW:0]   wi_q;
  logic          err_q, irq_q;
  logic [31:0]   bufm [WORDS];

  logic          size_ok, wr_ok, go, dir, range_ok, last, fill_we;
  logic [63:0]   wval;
  logic [31:0]   b32, e32;
  logic [HW-1:0] hsel;
  logic [BW:0]   nb;
  logic [IW:0]   nwords;
  logic [1:0]    tail;
  logic [IW-1:0] eng_idx;

  assign size_ok  = (reg_size == 4'd4) || (reg_size == 4'd8);
  assign wr_ok    = reg_wr && size_ok && !cmd_q[0];
  assign wval     = (reg_size == 4'd8) ? reg_wdata : {32'h0, reg_wdata[31:0]};
  assign go       = wr_ok && (reg_addr == A_CMD) && wval[0];
  assign dir      = cmd_q[1];

  assign b32      = dir ? src_q[31:0] : dst_q[31:0];
  assign e32      = b32 + cnt_q[31:0];
  assign range_ok = in_win(b32) && (e32 > b32) && in_win(e32);
  assign hsel     = dir ? dst_q[HOST_AW-1:2] : src_q[HOST_AW-1:2];

  assign nb       = {1'b0, cnt_q[BW-1:0]} + (BW+1)'(3);
  assign nwords   = nb[BW:2];
  assign last     = (wi_q + (IW+1)'(1)) == nwords;
  assign tail     = cnt_q[1:0];
  assign eng_idx  = b32[BW-1:2] + wi_q[IW-1:0];

  assign mem_req   = (st_q == S_XFER);
  assign mem_we    = dir;
  assign mem_addr  = {hsel + HW'(wi_q), 2'b00};
  assign mem_wdata = bufm[eng_idx];
  assign mem_be    = (last && tail != 2'd0) ? (4'hF >> (3'd4 - {1'b0, tail})) : 4'hF;
  assign fill_we   = mem_req && !dir && mem_ack;

  assign buf_rdata = bufm[buf_idx];
  assign irq_o     = irq_q;
  assign range_err = err_q;

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = src_q;
      A_DST:   reg_rdata = dst_q;
      A_CNT:   reg_rdata = cnt_q;
      A_CMD:   reg_rdata = {61'h0, cmd_q};
      default: reg_rdata = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (buf_wr) bufm[buf_idx] <= buf_wdata;
    if (fill_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) bufm[eng_idx][8*b +: 8] <= mem_rdata[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; cmd_q <= '0;
      st_q  <= S_IDLE; dly_q <= '0; wi_q <= '0;
      err_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_ok) begin
        case (reg_addr)
          A_SRC: src_q <= wval;
          A_DST: dst_q <= wval;
          A_CNT: cnt_q <= wval;
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE: if (go) begin
          cmd_q <= wval[2:0];
          dly_q <= DW'(DELAY_CYCLES);
          st_q  <= S_WAIT;
        end
        S_WAIT: if (dly_q <= DW'(1)) begin
          if (range_ok) begin
            wi_q <= '0;
            st_q <= S_XFER;
          end else begin
            err_q    <= 1'b1;
            cmd_q[0] <= 1'b0;
            irq_q    <= cmd_q[2];
            st_q     <= S_IDLE;
          end
        end else begin
          dly_q <= dly_q - DW'(1);
        end
        S_XFER: if (mem_ack) begin
          if (last) begin
            cmd_q[0] <= 1'b0;
            irq_q    <= cmd_q[2];
            st_q     <= S_IDLE;
          end else begin
            wi_q <= wi_q + (IW+1)'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic [31:0] wait_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)              wait_seen <= '0;
    else if (go)             wait_seen <= '0;
    else if (st_q == S_WAIT) wait_seen <= wait_seen + 32'd1;
  end

  p_lock_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && reg_wr && reg_addr == A_SRC) |=> $stable(src_q));

  p_lock_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && reg_wr && reg_addr == A_CNT) |=> $stable(cnt_q));

  p_delay_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (wait_seen == 32'(DELAY_CYCLES)));

  p_err_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_err) |-> (!mem_req && !cmd_q[0]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

  p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !cmd_q[0]);

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: tb/dly_dma_tb.sv
module dly_dma_tb;
  localparam int DLY = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [3:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        buf_wr = 1'b0;
  logic [9:0]  buf_idx = '0;
  logic [31:0] buf_wdata = '0, buf_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        irq_o, range_err;

  dly_dma #(.DELAY_CYCLES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_wr(buf_wr), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_o(irq_o), .range_err(range_err));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] hmem [256];
  int req_count = 0, irq_cnt = 0, stall = 0, wait_ctr = 0, hold_bad = 0;
  logic [27:0] first_addr = '0, hold_addr = '0;

  function automatic logic [31:0] hpat(input int i);
    return 32'h9E37_79B9 * 32'(i + 1);
  endfunction

  function automatic logic [31:0] fillv(input int i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    reg_addr = a; reg_size = sz; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr_buf(input int i, input logic [31:0] d);
    buf_idx = 10'(i); buf_wdata = d; buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic rd_buf(input int i, output logic [31:0] d);
    buf_idx = 10'(i); #1; d = buf_rdata;
  endtask

  task automatic wait_idle(output bit timed_out);
    logic [63:0] c;
    timed_out = 1'b1;
    for (int t = 0; t < 5000; t++) begin
      rd_reg(8'h98, c);
      if (!c[0]) begin timed_out = 1'b0; break; end
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    if (irq_o) irq_cnt++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_ctr < stall) begin
        if (wait_ctr == 0) hold_addr = mem_addr;
        else if (mem_addr != hold_addr) hold_bad++;
        wait_ctr++;
      end else begin
        if (req_count == 0) first_addr = mem_addr;
        req_count++;
        wait_ctr = 0;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) hmem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        end else begin
          mem_rdata = hmem[mem_addr[9:2]];
        end
        mem_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  typedef struct packed {
    logic        dir;
    logic        irq;
    logic [63:0] host;
    logic [31:0] bufa;
    logic [31:0] cnt;
    logic        err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b1, 64'h0000_0000_0000_0100, 32'h0004_0000, 32'd16, 1'b0},
    '{1'b0, 1'b0, 64'h0000_0003_1000_0040, 32'h0004_0010, 32'd7,  1'b0},
    '{1'b1, 1'b1, 64'h0000_0000_0000_0200, 32'h0004_0020, 32'd10, 1'b0},
    '{1'b1, 1'b0, 64'h0000_0000_F000_0300, 32'h0004_0FF0, 32'd14, 1'b0},
    '{1'b0, 1'b1, 64'h0000_0000_0000_0000, 32'h0004_0FF0, 32'd16, 1'b1},
    '{1'b1, 1'b1, 64'h0000_0000_0000_0000, 32'h0003_FFFC, 32'd8,  1'b1},
    '{1'b0, 1'b0, 64'h0000_0000_0000_0000, 32'h0004_0000, 32'd0,  1'b1}
  };

  initial begin
    logic [63:0] r;
    logic [31:0] w, ex, m;
    bit to, early, sticky_err;
    int nw, b0, h0, rem;

    for (int i = 0; i < 256; i++) hmem[i] = hpat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h80, r); chk(r == 0, "R1", "src after reset", r, 0);
    rd_reg(8'h98, r); chk(r == 0, "R1", "cmd after reset", r, 0);
    rd_reg(8'h00, r); chk(r == '1, "R1", "unmapped read", r, '1);
    chk(!mem_req && !irq_o && !range_err, "R1", "outputs after reset",
        {61'h0, mem_req, irq_o, range_err}, 0);

    // R2 access sizes
    wr_reg(8'h80, 4'd4, 64'hFFFF_FFFF_1234_5678);
    rd_reg(8'h80, r); chk(r == 64'h1234_5678, "R2", "32-bit write", r, 64'h1234_5678);
    wr_reg(8'h88, 4'd8, 64'hA5A5_0000_0004_0000);
    rd_reg(8'h88, r); chk(r == 64'hA5A5_0000_0004_0000, "R2", "64-bit write", r, 64'hA5A5_0000_0004_0000);
    wr_reg(8'h88, 4'd2, 64'h1);
    rd_reg(8'h88, r); chk(r == 64'hA5A5_0000_0004_0000, "R2", "bad size dropped", r, 64'hA5A5_0000_0004_0000);

    // R11 buffer port
    wr_buf(77, 32'hFACE_B00C);
    rd_buf(77, w); chk(w == 32'hFACE_B00C, "R11", "buffer word", {32'h0, w}, 64'hFACE_B00C);

    // R3 command without run is dropped
    req_count = 0;
    wr_reg(8'h98, 4'd4, 64'h6);
    repeat (DLY + 4) @(negedge clk);
    rd_reg(8'h98, r); chk(r == 0 && req_count == 0, "R3", "cmd without run", r, 0);

    // R3 lock during delay
    wr_reg(8'h80, 4'd8, 64'h0);
    wr_reg(8'h88, 4'd8, 64'h0004_0000);
    wr_reg(8'h90, 4'd8, 64'd4);
    wr_reg(8'h98, 4'd4, 64'h1);
    wr_reg(8'h80, 4'd8, 64'h555);
    wr_reg(8'h90, 4'd8, 64'd200);
    wr_reg(8'h98, 4'd4, 64'h3);
    rd_reg(8'h80, r); chk(r == 0, "R3", "src locked", r, 0);
    rd_reg(8'h90, r); chk(r == 4, "R3", "cnt locked", r, 4);
    rd_reg(8'h98, r); chk(r == 1, "R3", "cmd locked", r, 1);
    wait_idle(to);
    chk(!to, "R4", "locked transfer completes", {63'h0, to}, 0);

    // Table of transfers: R4..R8, R10, R5 sticky error
    sticky_err = 1'b0;
    foreach (VECS[v]) begin
      nw  = (int'(VECS[v].cnt) + 3) / 4;
      b0  = (int'(VECS[v].bufa) - 32'h0004_0000) / 4;
      h0  = int'(VECS[v].host[27:0]) / 4;
      rem = int'(VECS[v].cnt) % 4;
      for (int i = 0; i < 256; i++) hmem[i] = hpat(i);
      if (!VECS[v].err)
        for (int k = 0; k < nw; k++) wr_buf(b0 + k, fillv(b0 + k));
      wr_reg(8'h80, 4'd8, VECS[v].dir ? {32'h0, VECS[v].bufa} : VECS[v].host);
      wr_reg(8'h88, 4'd8, VECS[v].dir ? VECS[v].host : {32'h0, VECS[v].bufa});
      wr_reg(8'h90, 4'd8, {32'h0, VECS[v].cnt});
      req_count = 0; irq_cnt = 0;
      wr_reg(8'h98, 4'd4, {61'h0, VECS[v].irq, VECS[v].dir, 1'b1});
      early = mem_req;
      for (int d = 1; d < DLY; d++) begin
        @(negedge clk);
        if (mem_req) early = 1'b1;
      end
      chk(!early, "R4", $sformatf("vec %0d no request during delay", v), {63'h0, early}, 0);
      wait_idle(to);
      rd_reg(8'h98, r);
      chk(!to && r == {61'h0, VECS[v].irq, VECS[v].dir, 1'b0}, "R4",
          $sformatf("vec %0d cmd after completion", v), r, {61'h0, VECS[v].irq, VECS[v].dir, 1'b0});
      chk(irq_cnt == int'(VECS[v].irq), "R10", $sformatf("vec %0d irq pulses", v),
          64'(irq_cnt), 64'(VECS[v].irq));
      sticky_err = sticky_err | VECS[v].err;
      chk(range_err == sticky_err, "R5", $sformatf("vec %0d range_err", v),
          {63'h0, range_err}, {63'h0, sticky_err});
      chk(req_count == (VECS[v].err ? 0 : nw), "R5", $sformatf("vec %0d word count", v),
          64'(req_count), 64'(VECS[v].err ? 0 : nw));
      if (!VECS[v].err) begin
        chk(first_addr == {VECS[v].host[27:2], 2'b00}, "R6", $sformatf("vec %0d first host address", v),
            {36'h0, first_addr}, {36'h0, VECS[v].host[27:2], 2'b00});
        for (int k = 0; k < nw; k++) begin
          m = (k == nw - 1 && rem != 0) ? ((32'h1 << (8 * rem)) - 1) : 32'hFFFF_FFFF;
          if (!VECS[v].dir) begin
            rd_buf(b0 + k, w);
            ex = (hpat(h0 + k) & m) | (fillv(b0 + k) & ~m);
            chk(w == ex, "R7", $sformatf("vec %0d buffer word %0d", v, k), {32'h0, w}, {32'h0, ex});
          end else begin
            w  = hmem[h0 + k];
            ex = (fillv(b0 + k) & m) | (hpat(h0 + k) & ~m);
            chk(w == ex, "R8", $sformatf("vec %0d host word %0d", v, k), {32'h0, w}, {32'h0, ex});
          end
        end
      end
    end

    // R9 stalled memory: address held until acknowledge
    stall = 3; hold_bad = 0;
    for (int i = 0; i < 256; i++) hmem[i] = hpat(i);
    wr_buf(0, 32'h1111_2222);
    wr_buf(1, 32'h3333_4444);
    wr_reg(8'h80, 4'd8, 64'h0004_0000);
    wr_reg(8'h88, 4'd8, 64'h40);
    wr_reg(8'h90, 4'd8, 64'd8);
    req_count = 0;
    wr_reg(8'h98, 4'd4, 64'h3);
    wait_idle(to);
    chk(hold_bad == 0, "R9", "address stable while stalled", 64'(hold_bad), 0);
    chk(!to && req_count == 2 && hmem[16] == 32'h1111_2222 && hmem[17] == 32'h3333_4444,
        "R9", "stalled transfer data", {32'(req_count), hmem[17]}, {32'd2, 32'h3333_4444});
    stall = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule